// File: doc/BRIEF.md
# Framed Word Serializer with Sync Burst Generator

The block turns a parallel data word into a serial frame with an embedded clock. Each frame carries a leading marker bit that is always 1, the data bits with the least significant first, and a trailing marker bit that is always 0. The frame leaves the block one bit per fast bit clock. The word clock is derived internally as one frame period and is driven on `word_clk`, so that the data source can align to it. A select input picks the word-clock edge on which the parallel word is sampled. The sampled word waits in a holding register and is moved into the outgoing frame only at a frame boundary.

Two request inputs are OR-ed together. At each frame boundary the block checks whether a request has stayed high over consecutive boundaries. Once it qualifies, the block sends a fixed-length burst of sync symbols in place of user data. Each sync symbol is a run of ones over the first half of the frame and a run of zeros over the second half. If the request is still high when the burst ends, sync symbols keep going. A request that stays high for another qualification window starts a fresh burst.

A driver-enable input gates the serial output without disturbing the internal state. A power-down input clears the block. After power-down is released, the output stays disabled for a fixed number of word periods while the block initializes.

Top module: `serfr_top`

## Requirements
- R1: A data frame is 12 bits in the order bit 0 = 1 (start), bits 1..10 = D0..D9, bit 11 = 0 (stop), one bit per `clk`. `word_clk` is 1 during bits 0..5 of each frame and 0 during bits 6..11.
- R2: With `edge_sel`=1, `din` is sampled in bit cycle 11 and sent in the frame after next. With `edge_sel`=0, `din` is sampled in bit cycle 5 and sent in the next frame.
- R3: The frame on `ser_out` is fixed for its whole 12 bits. Changes on `din` part-way through a frame never alter the frame in flight.
- R4: `sync_req_a | sync_req_b` is sampled at each frame boundary (bit cycle 11). A burst starts only at the 6th consecutive boundary with the request high. A shorter request has no effect on the serial stream.
- R5: A burst sends exactly 1026 sync symbols, each 12'b000000111111 (bits 0..5 = 1, bits 6..11 = 0). `din` is ignored throughout, and the burst runs to the end even if the request drops.
- R6: If the request is high at the boundary after a burst ends, sync symbols continue for as long as it stays high. Its 6th consecutive high boundary after the burst starts a new 1026-symbol burst.
- R7: `payload_valid` is 1 exactly when `ser_en`=1, both requests are low, and the current frame is a data frame.
- R8: `ser_en` = `drv_en` & !`pwr_dn` & initialized, and `ser_out` is 0 whenever `ser_en`=0. `drv_en` does not affect frame timing, sync counting or data capture.
- R9: `pwr_dn`=1 clears all state. After it is released, `ser_en` stays 0 until 1026 frame boundaries have passed.
- R10: While `rst_n`=0 (synchronous), `ser_out`, `ser_en` and `payload_valid` are 0 and all counters are cleared. The block then initializes as after a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_dn | input | 1 | Power-down, clears state while high |
| drv_en | input | 1 | Serial driver enable |
| edge_sel | input | 1 | 1: sample on the word-clock rise, 0: on the fall |
| sync_req_a | input | 1 | Sync request, OR-ed with the other request |
| sync_req_b | input | 1 | Sync request, OR-ed with the other request |
| din | input | 10 | Parallel data word |
| word_clk | output | 1 | Derived word clock, high over the first half of a frame |
| ser_out | output | 1 | Serial frame bit |
| ser_en | output | 1 | Serial output enabled |
| payload_valid | output | 1 | Current bit belongs to a valid user-data frame |

## Verification
The bench changes `din` in the middle of frames under both sample-edge settings. A design that loaded the shifter directly from the input, or that sampled on the wrong edge, would send a word torn across two frames, or a word one frame off. Requests held for five boundaries must pass without any effect, and requests held for six must start a burst, so an off-by-one qualifier shows up either as a burst that should not happen or as a missing one. A request held through a whole burst checks that the burst lasts exactly 1026 symbols, that extension symbols follow, and that a second burst re-arms. A request dropped in the middle of the second burst checks that the burst is not cut short. Toggling the driver enable and cycling power-down catch an output that is not gated, or an initialization window that is too short or too long.

// File: rtl/serfr_pkg.sv
package serfr_pkg;
  localparam int DEF_DATA_W = 10;
  localparam int DEF_QUAL   = 6;
  localparam int DEF_BURST  = 1026;
  localparam int DEF_INIT   = 1026;

  typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_sel_e;
endpackage

// File: rtl/serfr_timing.sv
module serfr_timing #(
  parameter int FRAME_W  = 12,
  parameter int INIT_LEN = 1026,
  localparam int IDX_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_start,
  output logic             frame_last,
  output logic             mid_point,
  output logic             word_clk,
  output logic             init_done
);
  localparam int HALF   = FRAME_W / 2;
  localparam int INIT_W = $clog2(INIT_LEN + 1);

  logic [IDX_W-1:0]  idx_q;
  logic [INIT_W-1:0] init_left_q;

  assign bit_idx     = idx_q;
  assign frame_start = (idx_q == '0);
  assign frame_last  = (idx_q == IDX_W'(FRAME_W - 1));
  assign mid_point   = (idx_q == IDX_W'(HALF - 1));
  assign word_clk    = (idx_q < IDX_W'(HALF));
  assign init_done   = (init_left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      idx_q       <= '0;
      init_left_q <= INIT_W'(INIT_LEN);
    end else begin
      idx_q <= frame_last ? '0 : idx_q + IDX_W'(1);
      if (frame_last && !init_done)
        init_left_q <= init_left_q - INIT_W'(1);
    end
  end
endmodule

// File: rtl/serfr_sync_ctrl.sv
module serfr_sync_ctrl #(
  parameter int QUAL_CNT  = 6,
  parameter int BURST_LEN = 1026
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic req_a,
  input  logic req_b,
  input  logic frame_last,
  output logic req_any,
  output logic use_sync,
  output logic sync_start,
  output logic burst_active
);
  localparam int QW = $clog2(QUAL_CNT + 1);
  localparam int BW = $clog2(BURST_LEN + 1);

  logic [QW-1:0] qual_q;
  logic [BW-1:0] left_q;
  logic          ext_q;

  function automatic logic qualifies(logic [QW-1:0] q, logic r);
    return r && (q == QW'(QUAL_CNT - 1));
  endfunction

  assign req_any      = req_a | req_b;
  assign burst_active = (left_q != '0);
  assign sync_start   = frame_last && !burst_active && qualifies(qual_q, req_any);
  assign use_sync     = sync_start || burst_active || (ext_q && req_any);

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      qual_q <= '0;
      left_q <= '0;
      ext_q  <= 1'b0;
    end else if (frame_last) begin
      if (sync_start) begin
        left_q <= BW'(BURST_LEN - 1);
        qual_q <= '0;
      end else if (burst_active) begin
        left_q <= left_q - BW'(1);
        qual_q <= '0;
      end else begin
        qual_q <= req_any ? qual_q + QW'(1) : '0;
      end
      ext_q <= use_sync;
    end
  end
endmodule

// File: rtl/serfr_framer.sv
module serfr_framer
  import serfr_pkg::*;
#(
  parameter int DATA_W   = 10,
  localparam int FRAME_W = DATA_W + 2,
  localparam int IDX_W   = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_dn,
  input  logic [DATA_W-1:0]  din,
  input  logic               edge_sel,
  input  logic               frame_last,
  input  logic               mid_point,
  input  logic               use_sync,
  input  logic [IDX_W-1:0]   bit_idx,
  output logic [FRAME_W-1:0] frame_word,
  output logic               frame_bit,
  output logic               is_data
);
  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] frame_q;
  logic               data_q;
  logic               capture;

  function automatic logic [FRAME_W-1:0] pack_word(logic [DATA_W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  function automatic logic [FRAME_W-1:0] sync_symbol();
    logic [FRAME_W-1:0] s;
    for (int i = 0; i < FRAME_W; i++) s[i] = (i < FRAME_W / 2);
    return s;
  endfunction

  assign capture    = (edge_sel == EDGE_RISE) ? frame_last : mid_point;
  assign frame_word = frame_q;
  assign frame_bit  = frame_q[bit_idx];
  assign is_data    = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      hold_q  <= '0;
      frame_q <= '0;
      data_q  <= 1'b0;
    end else begin
      if (capture) hold_q <= din;
      if (frame_last) begin
        frame_q <= use_sync ? sync_symbol() : pack_word(hold_q);
        data_q  <= !use_sync;
      end
    end
  end
endmodule

// File: rtl/serfr_top.sv
module serfr_top
  import serfr_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int QUAL_CNT  = DEF_QUAL,
  parameter int BURST_LEN = DEF_BURST,
  parameter int INIT_LEN  = DEF_INIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              drv_en,
  input  logic              edge_sel,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic [DATA_W-1:0] din,
  output logic              word_clk,
  output logic              ser_out,
  output logic              ser_en,
  output logic              payload_valid
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [IDX_W-1:0]   bit_idx;
  logic               frame_start, frame_last, mid_point, init_done;
  logic               req_any, use_sync, sync_start, burst_active;
  logic [FRAME_W-1:0] frame_word;
  logic               frame_bit, is_data;

  serfr_timing #(.FRAME_W(FRAME_W), .INIT_LEN(INIT_LEN)) u_timing (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
    .bit_idx(bit_idx), .frame_start(frame_start), .frame_last(frame_last),
    .mid_point(mid_point), .word_clk(word_clk), .init_done(init_done)
  );

  serfr_sync_ctrl #(.QUAL_CNT(QUAL_CNT), .BURST_LEN(BURST_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
    .req_a(sync_req_a), .req_b(sync_req_b), .frame_last(frame_last),
    .req_any(req_any), .use_sync(use_sync), .sync_start(sync_start),
    .burst_active(burst_active)
  );

  serfr_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .din(din), .edge_sel(edge_sel),
    .frame_last(frame_last), .mid_point(mid_point), .use_sync(use_sync),
    .bit_idx(bit_idx), .frame_word(frame_word), .frame_bit(frame_bit),
    .is_data(is_data)
  );

  assign ser_en        = drv_en && !pwr_dn && init_done;
  assign ser_out       = ser_en && frame_bit;
  assign payload_valid = ser_en && !req_any && is_data;
endmodule

// File: rtl/serfr_chk.sv
module serfr_chk #(
  parameter int FRAME_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_dn,
  input logic               drv_en,
  input logic               sync_req_a,
  input logic               sync_req_b,
  input logic               ser_out,
  input logic               ser_en,
  input logic               payload_valid,
  input logic               frame_start,
  input logic               frame_last,
  input logic [FRAME_W-1:0] frame_word,
  input logic               burst_active
);
  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && frame_start) |-> ser_out);

  p_stop_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && frame_last) |-> !ser_out);

  p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
    !frame_last |=> $stable(frame_word));

  p_no_data_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> !payload_valid);

  p_valid_needs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    payload_valid |-> (ser_en && !sync_req_a && !sync_req_b));

  p_gate_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> !ser_out);

  p_drv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !ser_en);

  p_wake_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn) |-> !ser_en);
endmodule

bind serfr_top serfr_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .drv_en(drv_en),
  .sync_req_a(sync_req_a), .sync_req_b(sync_req_b), .ser_out(ser_out),
  .ser_en(ser_en), .payload_valid(payload_valid), .frame_start(frame_start),
  .frame_last(frame_last), .frame_word(frame_word), .burst_active(burst_active)
);

// File: tb/sim_serfr_top.sv
module sim_serfr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, pwr_dn = 1'b0, drv_en = 1'b1, edge_sel = 1'b1;
  logic       sync_req_a = 1'b0, sync_req_b = 1'b0;
  logic [9:0] din = '0;
  logic       word_clk, ser_out, ser_en, payload_valid;

  always #4 clk = ~clk;

  serfr_top u0 (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .drv_en(drv_en), .edge_sel(edge_sel),
    .sync_req_a(sync_req_a), .sync_req_b(sync_req_b), .din(din),
    .word_clk(word_clk), .ser_out(ser_out), .ser_en(ser_en), .payload_valid(payload_valid)
  );

  int    checks = 0, failures = 0, cyc = 0;
  string tag = "R10";
  bit    armed = 1'b0;

  // behavioural reference
  int          m_pos, m_qual, m_left, m_init;
  bit          m_ext, m_data;
  logic [9:0]  m_hold;
  bit          m_bits[12];

  always @(posedge clk) begin
    bit req, snd;
    logic [9:0] nh;
    req = sync_req_a || sync_req_b;
    if (!rst_n || pwr_dn) begin
      m_pos = 0; m_qual = 0; m_left = 0; m_init = 1026; m_ext = 0; m_data = 0;
      m_hold = '0;
      foreach (m_bits[i]) m_bits[i] = 0;
    end else begin
      nh = m_hold;
      if ((edge_sel && m_pos == 11) || (!edge_sel && m_pos == 5)) nh = din;
      if (m_pos == 11) begin
        if (m_init > 0) m_init--;
        if (m_left == 0 && req && m_qual == 5) begin
          snd = 1; m_left = 1025; m_qual = 0;
        end else if (m_left > 0) begin
          snd = 1; m_left--; m_qual = 0;
        end else begin
          snd = m_ext && req;
          m_qual = req ? m_qual + 1 : 0;
        end
        m_ext = snd; m_data = !snd;
        for (int i = 0; i < 12; i++)
          if (snd) m_bits[i] = (i < 6);
          else if (i == 0) m_bits[i] = 1;
          else if (i == 11) m_bits[i] = 0;
          else m_bits[i] = m_hold[i-1];
      end
      m_pos = (m_pos == 11) ? 0 : m_pos + 1;
      m_hold = nh;
    end
  end

  always @(posedge clk) begin
    bit e_en, e_out, e_pv, e_wc;
    #2;
    cyc++;
    if (armed) begin
      e_en  = drv_en && !pwr_dn && m_init == 0;
      e_out = e_en && m_bits[m_pos];
      e_pv  = e_en && !(sync_req_a || sync_req_b) && m_data;
      e_wc  = m_pos < 6;
      checks++;
      if (ser_en !== e_en || ser_out !== e_out || payload_valid !== e_pv || word_clk !== e_wc) begin
        failures++;
        $display("FAIL %s cyc=%0d en/out/pv/wclk actual=%b%b%b%b expected=%b%b%b%b",
                 tag, cyc, ser_en, ser_out, payload_valid, word_clk, e_en, e_out, e_pv, e_wc);
      end
    end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired in %s actual=hung expected=done", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic frames(int n);
    repeat (n * 12) @(negedge clk);
  endtask

  task automatic check_frame_r1(logic [9:0] w);
    logic [11:0] got, exp;
    @(negedge clk);
    while (!(word_clk === 1'b1)) @(negedge clk);
    while (word_clk === 1'b1) @(negedge clk);
    @(negedge clk);
    while (!(word_clk === 1'b1)) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      got[k] = ser_out;
      exp[k] = (k == 0) ? 1'b1 : (k == 11) ? 1'b0 : w[k-1];
      if (k < 11) @(negedge clk);
    end
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R1 frame bits actual=%b expected=%b", got, exp);
    end
  endtask

  initial begin
    logic [9:0] lf;
    lf = 10'h1C3;
    @(posedge clk);
    armed = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (ser_out !== 1'b0 || ser_en !== 1'b0 || payload_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset outputs actual=%b%b%b expected=000", ser_out, ser_en, payload_valid);
    end
    rst_n = 1'b1;

    tag = "R9";  frames(1028);
    tag = "R1";  din = 10'h2A5; frames(3); check_frame_r1(10'h2A5);
    din = 10'h0F1; frames(3); check_frame_r1(10'h0F1);

    tag = "R3";
    for (int k = 0; k < 240; k++) begin
      @(negedge clk);
      if (k % 5 == 0) begin lf = {lf[8:0], lf[9] ^ lf[6]}; din = lf; end
    end

    tag = "R2"; edge_sel = 1'b0;
    for (int k = 0; k < 180; k++) begin
      @(negedge clk);
      lf = {lf[8:0], lf[9] ^ lf[6]}; din = lf;
    end
    edge_sel = 1'b1;

    tag = "R4";
    @(negedge clk); sync_req_b = 1'b1; frames(5); sync_req_b = 1'b0; frames(3);
    repeat (5) @(negedge clk); sync_req_a = 1'b1; frames(3); sync_req_a = 1'b0; frames(3);

    tag = "R5";
    sync_req_a = 1'b1; frames(7); sync_req_a = 1'b0;
    for (int k = 0; k < 1030 * 12; k++) begin
      @(negedge clk);
      if (k % 7 == 0) begin lf = {lf[8:0], lf[9] ^ lf[6]}; din = lf; end
    end

    tag = "R6";
    sync_req_a = 1'b1; sync_req_b = 1'b1; frames(1046);
    sync_req_a = 1'b0; sync_req_b = 1'b0; frames(1030);

    tag = "R8";
    for (int k = 0; k < 8; k++) begin
      drv_en = 1'b0; repeat (17) @(negedge clk);
      drv_en = 1'b1; repeat (9) @(negedge clk);
      din = din ^ 10'h155;
    end
    frames(2); check_frame_r1(din);

    tag = "R7";
    sync_req_b = 1'b1; frames(2); sync_req_b = 1'b0; frames(2);
    drv_en = 1'b0; sync_req_a = 1'b1; repeat (13) @(negedge clk);
    sync_req_a = 1'b0; drv_en = 1'b1; frames(2);

    tag = "R9";
    pwr_dn = 1'b1; repeat (30) @(negedge clk); pwr_dn = 1'b0;
    din = 10'h3C6; frames(1029); check_frame_r1(10'h3C6);

    tag = "R10";
    rst_n = 1'b0; repeat (2) @(negedge clk);
    checks++;
    if (ser_en !== 1'b0 || ser_out !== 1'b0) begin
      failures++;
      $display("FAIL R10 mid-run reset actual=%b%b expected=00", ser_en, ser_out);
    end
    rst_n = 1'b1; frames(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule